// File: doc/BRIEF.md
# Twelve-Bit-Unit Operand Extractor

This block loads 36-, 48- and 60-bit operands from a densely packed array in a memory that is addressed in 12-bit units. Software gives an element index and an element type. The block scales the index into 12-bit units (by 3, 4 or 5) and then into a nibble address (by 3). It asks the memory for a 128-bit window that starts at the 64-bit word holding the first nibble. It then shifts the window right in 4-bit steps and masks the result, so the operand comes out right-aligned at its natural width.

The block has two pipeline stages. In the cycle after a request is accepted, the window word address is on `win_addr_o`, and the memory must return the window on `win_data_i` in that same cycle. The operand and its valid flag appear in the cycle after that. The element array starts at nibble 0 of the memory.

Top module: `operand_extract_12u`

## Requirements
- R1: While reset is held and after it is released, `valid_o` is 0 and `operand_o` is all zeros until the first result is produced.
- R2: The type codes are 0 for a 36-bit element, 1 for 48-bit and 2 for 60-bit. The element's 12-bit-unit address is the index times 3, 4 or 5 for these types.
- R3: The nibble address is the unit address times 3. One cycle after a request is accepted, `win_addr_o` holds the nibble address divided by 16 (rounded down), which is the 64-bit word index.
- R4: Two cycles after a request is accepted, `valid_o` is 1 for one cycle. `operand_o` then holds the element's bits, taken from `win_data_i` starting at bit 4*(nibble address mod 16). The bits above the element width are zero.
- R5: 36-bit and 60-bit elements are extracted correctly at every nibble offset they reach inside a word, including offsets where the element runs across a 64-bit word boundary.
- R6: 48-bit elements always sit at a nibble offset that is a multiple of 4 (0, 4, 8 or 12) and are extracted correctly.
- R7: Type code 3 is reserved. A request with this code produces no result: `valid_o` stays 0 and `operand_o` keeps its previous value.
- R8: Requests issued in consecutive cycles each produce exactly one result, in the order they were issued, with no bubbles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_type_i | input | 2 | Element type code (0: 36, 1: 48, 2: 60, 3: reserved) |
| req_idx_i | input | IDX_W | Element index |
| win_addr_o | output | IDX_W+1 | 64-bit word index of the window start |
| win_data_i | input | WIN_W | 128-bit window returned by the memory in the same cycle |
| operand_o | output | OUT_W | Right-aligned operand |
| valid_o | output | 1 | Operand valid |

## Verification
The testbench fills the memory with random operands packed end to end, one array for each type, and extracts every element of that array. This covers all offsets that 36-bit and 60-bit elements reach, both inside a word and across a word boundary, and all four offsets a 48-bit element can have. Random contents show up an extract that starts at the wrong nibble or masks to the wrong width; all-ones contents show up upper bits that were not cleared. A table of index and type pairs pins the word address, so an addressing fault is told apart from a shifter fault. A back-to-back burst checks that results come out in order, and a request with the reserved code checks that no result is produced and the output is held.

// File: rtl/opx_pkg.sv
package opx_pkg;
  typedef enum logic [1:0] {
    ELEM_36  = 2'd0,
    ELEM_48  = 2'd1,
    ELEM_60  = 2'd2,
    ELEM_RSV = 2'd3
  } elem_t;

  localparam int unsigned UNIT_BITS = 12;
  localparam int unsigned NIB_BITS  = 4;
  localparam int unsigned W36 = 36;
  localparam int unsigned W48 = 48;
  localparam int unsigned W60 = 60;
endpackage

// File: rtl/opx_addr_gen.sv
module opx_addr_gen
  import opx_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  localparam int unsigned UNIT_W = IDX_W + 3,
  localparam int unsigned NIB_W  = UNIT_W + 2
) (
  input  logic [IDX_W-1:0] idx_i,
  input  elem_t            type_i,
  output logic [NIB_W-1:0] nib_addr_o
);
  logic [UNIT_W-1:0] idx_ext;
  logic [UNIT_W-1:0] unit_addr;

  assign idx_ext = UNIT_W'(idx_i);

  // scale by 3, 4 or 5 using shift-and-add
  always_comb begin
    unique case (type_i)
      ELEM_36: unit_addr = (idx_ext << 1) + idx_ext;
      ELEM_48: unit_addr = idx_ext << 2;
      ELEM_60: unit_addr = (idx_ext << 2) + idx_ext;
      default: unit_addr = '0;
    endcase
  end

  // a 12-bit unit is three nibbles
  assign nib_addr_o = (NIB_W'(unit_addr) << 1) + NIB_W'(unit_addr);
endmodule

// File: rtl/opx_nib_shift.sv
module opx_nib_shift #(
  parameter int unsigned WIN_W = 128,
  parameter int unsigned SH_W  = 4
) (
  input  logic [WIN_W-1:0] data_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [WIN_W-1:0] data_o
);
  logic [WIN_W-1:0] stage [SH_W+1];

  assign stage[0] = data_i;

  // log stages, stage s moves 4*2^s bits
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stage[s+1] = sh_i[s] ? (stage[s] >> (4 * (1 << s))) : stage[s];
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/opx_width_mask.sv
module opx_width_mask
  import opx_pkg::*;
#(
  parameter int unsigned OUT_W = 60
) (
  input  logic [OUT_W-1:0] raw_i,
  input  elem_t            type_i,
  output logic [OUT_W-1:0] data_o
);
  localparam logic [OUT_W-1:0] M36 = OUT_W'((65'd1 << W36) - 65'd1);
  localparam logic [OUT_W-1:0] M48 = OUT_W'((65'd1 << W48) - 65'd1);
  localparam logic [OUT_W-1:0] M60 = OUT_W'((65'd1 << W60) - 65'd1);

  logic [OUT_W-1:0] mask;

  always_comb begin
    unique case (type_i)
      ELEM_36: mask = M36;
      ELEM_48: mask = M48;
      ELEM_60: mask = M60;
      default: mask = '0;
    endcase
  end

  assign data_o = raw_i & mask;
endmodule

// File: rtl/operand_extract_12u.sv
module operand_extract_12u
  import opx_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned WIN_W  = 128,
  parameter int unsigned OUT_W  = 60,
  localparam int unsigned NIB_W   = IDX_W + 5,
  localparam int unsigned SH_W    = $clog2(WORD_W / NIB_BITS),
  localparam int unsigned WADDR_W = NIB_W - SH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_type_i,
  input  logic [IDX_W-1:0]   req_idx_i,
  output logic [WADDR_W-1:0] win_addr_o,
  input  logic [WIN_W-1:0]   win_data_i,
  output logic [OUT_W-1:0]   operand_o,
  output logic               valid_o
);
  elem_t            req_type;
  logic [NIB_W-1:0] nib_addr;
  logic             req_ok;

  assign req_type = elem_t'(req_type_i);
  assign req_ok   = req_valid_i && (req_type != ELEM_RSV);

  opx_addr_gen #(.IDX_W(IDX_W)) i_addr_gen (
    .idx_i      (req_idx_i),
    .type_i     (req_type),
    .nib_addr_o (nib_addr)
  );

  // stage 1: window address to memory
  logic               s1_valid_q;
  elem_t              s1_type_q;
  logic [SH_W-1:0]    s1_sh_q;
  logic [WADDR_W-1:0] s1_waddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_type_q  <= ELEM_36;
      s1_sh_q    <= '0;
      s1_waddr_q <= '0;
    end else begin
      s1_valid_q <= req_ok;
      if (req_ok) begin
        s1_type_q  <= req_type;
        s1_sh_q    <= nib_addr[SH_W-1:0];
        s1_waddr_q <= nib_addr[NIB_W-1:SH_W];
      end
    end
  end

  assign win_addr_o = s1_waddr_q;

  logic [WIN_W-1:0] shifted;
  logic [OUT_W-1:0] masked;

  opx_nib_shift #(.WIN_W(WIN_W), .SH_W(SH_W)) i_nib_shift (
    .data_i (win_data_i),
    .sh_i   (s1_sh_q),
    .data_o (shifted)
  );

  opx_width_mask #(.OUT_W(OUT_W)) i_width_mask (
    .raw_i  (shifted[OUT_W-1:0]),
    .type_i (s1_type_q),
    .data_o (masked)
  );

  // stage 2: aligned operand
  elem_t out_type_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      operand_o  <= '0;
      out_type_q <= ELEM_36;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        operand_o  <= masked;
        out_type_q <= s1_type_q;
      end
    end
  end

  AST_REQ_TO_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q == $past(req_valid_i && (req_type_i != 2'd3))); // R7
  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(s1_valid_q)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(operand_o)); // R7
  AST_UPPER_ZERO_36: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_type_q == ELEM_36) |-> (operand_o[OUT_W-1:W36] == '0)); // R4
  AST_UPPER_ZERO_48: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_type_q == ELEM_48) |-> (operand_o[OUT_W-1:W48] == '0)); // R4
  AST_ALIGN_48: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_type_q == ELEM_48) |-> (s1_sh_q[1:0] == 2'b00)); // R6
endmodule

// File: tb/test_operand_extract_12u.sv
module test_operand_extract_12u;
  localparam int IDX_W    = 16;
  localparam int WADDR_W  = IDX_W + 1;
  localparam int NELEM    = 32;
  localparam int MEM_BITS = 2112;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid_i = 1'b0;
  logic [1:0]         req_type_i = 2'd0;
  logic [IDX_W-1:0]   req_idx_i = '0;
  logic [WADDR_W-1:0] win_addr_o;
  logic [127:0]       win_data_i;
  logic [59:0]        operand_o;
  logic               valid_o;

  logic [MEM_BITS-1:0] memv = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  operand_extract_12u #(.IDX_W(IDX_W)) i_operand_extract_12u (
    .clk_i, .rst_ni, .req_valid_i, .req_type_i, .req_idx_i,
    .win_addr_o, .win_data_i, .operand_o, .valid_o
  );

  // memory model: 128-bit window from any 64-bit word
  always_comb begin
    int a;
    a = int'(win_addr_o) * 64;
    if (a + 128 <= MEM_BITS) win_data_i = memv[a +: 128];
    else win_data_i = '0;
  end

  function automatic int width_of(input logic [1:0] t);
    return (t == 2'd0) ? 36 : (t == 2'd1) ? 48 : 60;
  endfunction

  function automatic logic [59:0] expect_elem(input logic [1:0] t, input int e);
    int w;
    logic [63:0] raw;
    w = width_of(t);
    raw = memv[e*w +: 64];
    return 60'(raw & ((64'd1 << w) - 64'd1));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] t, input bit ones);
    int w;
    w = width_of(t);
    memv = '0;
    for (int e = 0; e < NELEM; e++) begin
      logic [63:0] v;
      v = ones ? '1 : {$urandom, $urandom};
      for (int b = 0; b < w; b++) memv[e*w + b] = v[b];
    end
  endtask

  // one isolated request; returns after the result cycle is sampled
  task automatic one_req(input logic [1:0] t, input int idx, input string tag);
    logic [59:0] prev;
    @(negedge clk_i);
    prev = operand_o;
    req_valid_i = 1'b1; req_type_i = t; req_idx_i = IDX_W'(idx);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    if (t == 2'd3) begin
      check({tag, " R7 valid"}, 64'(valid_o), 64'd0);
      check({tag, " R7 hold"}, 64'(operand_o), 64'(prev));
    end else begin
      check({tag, " R4 valid"}, 64'(valid_o), 64'd1);
      check(tag, 64'(operand_o), 64'(expect_elem(t, idx)));
    end
  endtask

  typedef struct packed {
    logic [1:0] t;
    int         idx;
    int         waddr;
  } vec_t;

  // R2 R3: nibble = idx*{3,4,5}*3, word = nibble/16
  localparam vec_t VECS [8] = '{
    '{2'd2, 0,  0},
    '{2'd0, 1,  0},
    '{2'd0, 7,  3},
    '{2'd1, 5,  3},
    '{2'd2, 3,  2},
    '{2'd1, 31, 23},
    '{2'd2, 31, 29},
    '{2'd0, 30, 16}
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", 64'(valid_o), 64'd0);
    check("R1 operand in reset", 64'(operand_o), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 valid after reset", 64'(valid_o), 64'd0);
    check("R1 operand after reset", 64'(operand_o), 64'd0);

    // address table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      req_valid_i = 1'b1; req_type_i = VECS[i].t; req_idx_i = IDX_W'(VECS[i].idx);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      check($sformatf("R3 win_addr vec %0d", i), 64'(win_addr_o), 64'(VECS[i].waddr));
      @(negedge clk_i);
    end

    // every element of every type, random then all-ones
    for (int pass = 0; pass < 2; pass++) begin
      for (int t = 0; t < 3; t++) begin
        fill(2'(t), pass == 1);
        for (int e = 0; e < NELEM; e++) begin
          string tg;
          tg = (t == 1) ? "R6 elem48" : (t == 0) ? "R5 elem36" : "R5 elem60";
          one_req(2'(t), e, $sformatf("%s idx %0d R2 R4", tg, e));
        end
      end
    end

    // reserved type
    fill(2'd2, 1'b0);
    one_req(2'd2, 4, "R4 before reserved");
    one_req(2'd3, 1, "R7 reserved");
    one_req(2'd3, 9, "R7 reserved again");

    // back-to-back burst
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (k >= 2) begin
        check($sformatf("R8 burst valid %0d", k - 2), 64'(valid_o), 64'd1);
        check($sformatf("R8 burst data %0d", k - 2), 64'(operand_o),
              64'(expect_elem(2'd2, 10 + k - 2)));
      end
      if (k < 6) begin
        req_valid_i = 1'b1; req_type_i = 2'd2; req_idx_i = IDX_W'(10 + k);
      end else begin
        req_valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    check("R8 burst end", 64'(valid_o), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule